// File: doc/BRIEF.md
# Two-Phase Bus Cycle Controller

This block turns a fast system clock into the two bus clock phases of an 8-bit microprocessor system bus and runs one complete bus cycle per phase pair. Each cycle begins when the first phase rises. The controller samples the CPU core's address, read/write flag and write data on the last system clock of the first phase. During the second phase it raises the matching chip select and, on writes, drives the data bus.

Five regions share a fixed 16-bit address map: internal work RAM, the picture-unit register window, the audio/controller register window, cartridge RAM and cartridge program ROM. Every chip select is qualified by the second phase, so no device is ever enabled outside it. Read data is captured at the end of the second phase, and a one-clock strobe then tells the CPU core that it may advance. A read from an address outside every region returns the last value that was on the data bus.

Top module: `bus_phase_ctrl`

## Requirements
- R1: The first phase is high for system clocks 0 to PH_LEN-1 of each cycle of 2*(PH_LEN+DEAD) clocks. The second phase is high for clocks PH_LEN+DEAD to 2*PH_LEN+DEAD-1. The two phases are never high together.
- R2: At least DEAD (>=1) system clocks in which both phases are low separate the fall of either phase from the rise of the other.
- R3: Address, read/write flag (1 = read) and write data are sampled on the last clock of the first phase. `bus_addr` stays stable throughout the second phase.
- R4: Chip selects are high only during the second phase and decode the sampled address as follows. Work RAM is 0x0000-0x1FFF. Picture unit is 0x2000-0x3FFF. Audio/controller is 0x4000-0x401F. Cartridge RAM is 0x6000-0x7FFF. Program ROM is 0x8000-0xFFFF (top bit set). Every other address selects nothing.
- R5: At most one chip select is high at a time. `ram_offs` is address bits 10:0 (RAM mirrored every 2 KiB). `ppu_sel` is bits 2:0 (mirrored every 8 bytes). `io_sel` is bits 4:0.
- R6: On a write, `drive_en` is high from WR_DLY clocks after the second phase rises until the second phase falls, and low at all other times. While it is high, `bus_wdata` equals the sampled write data.
- R7: On a read from a mapped region, `bus_rdata` is captured on the last clock of the second phase and appears on `rd_data` in the next clock. `rd_data` is held until the next capture.
- R8: On a read from an unmapped address, `rd_data` keeps the last value seen on the data bus, which is either the previous read data or the previous write data. A write cycle makes its own data the new bus value.
- R9: `cyc_done` pulses high for exactly one clock: the clock after the second phase's last clock. It is low in every other clock.
- R10: While `rst` is high, both phases, all chip selects, `drive_en` and `cyc_done` are low. After `rst` is released, the first clock begins a new cycle with the first phase high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Address from the CPU core |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Write data from the CPU core |
| bus_rdata | input | 8 | Data returned by the selected device |
| phi1 | output | 1 | First bus phase |
| phi2 | output | 1 | Second bus phase |
| cs_ram | output | 1 | Work RAM select |
| cs_ppu | output | 1 | Picture-unit register select |
| cs_io | output | 1 | Audio/controller register select |
| cs_cram | output | 1 | Cartridge RAM select |
| cs_rom | output | 1 | Program ROM select |
| bus_addr | output | 16 | Sampled address |
| ram_offs | output | 11 | Mirrored work RAM offset |
| ppu_sel | output | 3 | Mirrored picture-unit register index |
| io_sel | output | 5 | Audio/controller register index |
| bus_wdata | output | 8 | Write data on the bus |
| drive_en | output | 1 | Data-bus drive enable for writes |
| rd_data | output | 8 | Latched read data / last bus value |
| cyc_done | output | 1 | End-of-cycle strobe |

## Verification
Phases, chip selects and `drive_en` are combinational functions of the cycle counter and the sampled address, so they are due in the same clock as the counter position. `rd_data` and `cyc_done` lag the last second-phase clock by one register. The bench keeps its own position counter, restarted at the clock in which reset is released. It drives the inputs on the falling edge and samples one time unit later, so each check compares against the value expected at that exact counter position. The bench also sweeps every 16-byte address block with mixed reads and writes, which covers every region boundary and the open-bus value that each cycle leaves behind.

// File: rtl/bus_phase_ctrl.sv
module bus_phase_ctrl #(
  parameter int PH_LEN = 4,
  parameter int DEAD   = 2,
  parameter int WR_DLY = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rw,
  input  logic [7:0]  cpu_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        phi1,
  output logic        phi2,
  output logic        cs_ram,
  output logic        cs_ppu,
  output logic        cs_io,
  output logic        cs_cram,
  output logic        cs_rom,
  output logic [15:0] bus_addr,
  output logic [10:0] ram_offs,
  output logic [2:0]  ppu_sel,
  output logic [4:0]  io_sel,
  output logic [7:0]  bus_wdata,
  output logic        drive_en,
  output logic [7:0]  rd_data,
  output logic        cyc_done
);
  localparam int HALF   = PH_LEN + DEAD;
  localparam int CYC    = 2 * HALF;
  localparam int P2_END = HALF + PH_LEN;
  localparam int CW     = $clog2(CYC);
  localparam logic [CW-1:0] C_LAST  = CW'(CYC - 1);
  localparam logic [CW-1:0] C_P1END = CW'(PH_LEN);
  localparam logic [CW-1:0] C_SAMP  = CW'(PH_LEN - 1);
  localparam logic [CW-1:0] C_P2BEG = CW'(HALF);
  localparam logic [CW-1:0] C_P2END = CW'(P2_END);
  localparam logic [CW-1:0] C_CAPT  = CW'(P2_END - 1);
  localparam logic [CW-1:0] C_DRV   = CW'(HALF + WR_DLY);

  logic [CW-1:0] cnt;
  logic [15:0]   addr_q;
  logic          rw_q;
  logic [7:0]    wd_q;
  logic [7:0]    rd_q;
  logic          done_q;
  logic          dec_ram, dec_ppu, dec_io, dec_cram, dec_rom, mapped;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == C_LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign phi1 = !rst && (cnt < C_P1END);
  assign phi2 = !rst && (cnt >= C_P2BEG) && (cnt < C_P2END);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      rw_q   <= 1'b1;
      wd_q   <= '0;
    end else if (cnt == C_SAMP) begin
      addr_q <= cpu_addr;
      rw_q   <= cpu_rw;
      wd_q   <= cpu_wdata;
    end
  end

  assign dec_ram  = addr_q[15:13] == 3'b000;
  assign dec_ppu  = addr_q[15:13] == 3'b001;
  assign dec_io   = addr_q[15:5]  == 11'h200;
  assign dec_cram = addr_q[15:13] == 3'b011;
  assign dec_rom  = addr_q[15];
  assign mapped   = dec_ram | dec_ppu | dec_io | dec_cram | dec_rom;

  assign cs_ram  = phi2 & dec_ram;
  assign cs_ppu  = phi2 & dec_ppu;
  assign cs_io   = phi2 & dec_io;
  assign cs_cram = phi2 & dec_cram;
  assign cs_rom  = phi2 & dec_rom;

  assign bus_addr  = addr_q;
  assign ram_offs  = addr_q[10:0];
  assign ppu_sel   = addr_q[2:0];
  assign io_sel    = addr_q[4:0];
  assign bus_wdata = wd_q;
  assign drive_en  = phi2 && !rw_q && (cnt >= C_DRV);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt == C_CAPT);
      if (cnt == C_CAPT) begin
        if (!rw_q)       rd_q <= wd_q;
        else if (mapped) rd_q <= bus_rdata;
      end
    end
  end

  assign rd_data  = rd_q;
  assign cyc_done = done_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(phi1 && phi2)); // R1
  AST_GAP_AFTER_P1: assert property (@(posedge clk) disable iff (rst)
    $fell(phi1) |-> !phi2); // R2
  AST_GAP_AFTER_P2: assert property (@(posedge clk) disable iff (rst)
    $fell(phi2) |-> !phi1); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    phi2 |-> $stable(bus_addr)); // R3
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_ram, cs_ppu, cs_io, cs_cram, cs_rom})); // R5
  AST_DRIVE_IN_P2: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> phi2 && !phi1); // R6
  AST_DONE_AFTER_P2: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> $past(phi2) && !phi2); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done); // R9
endmodule

// File: tb/tb_bus_phase_ctrl.sv
module tb_bus_phase_ctrl;
  localparam int TCLK = 10;
  localparam int PL = 3, DD = 1, WD = 1;
  localparam int HALF = PL + DD;
  localparam int CYC = 2 * HALF;

  logic clk = 1'b0;
  logic rst;
  logic [15:0] cpu_addr;
  logic cpu_rw;
  logic [7:0] cpu_wdata, bus_rdata;
  logic phi1, phi2, cs_ram, cs_ppu, cs_io, cs_cram, cs_rom, drive_en, cyc_done;
  logic [15:0] bus_addr;
  logic [10:0] ram_offs;
  logic [2:0] ppu_sel;
  logic [4:0] io_sel;
  logic [7:0] bus_wdata, rd_data;

  int total = 0;
  int bad = 0;
  bit fin = 0;

  always #(TCLK/2) clk = ~clk;

  assign bus_rdata = bus_addr[7:0] ^ bus_addr[15:8] ^ 8'h5A;

  bus_phase_ctrl #(.PH_LEN(PL), .DEAD(DD), .WR_DLY(WD)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_wdata(cpu_wdata), .bus_rdata(bus_rdata), .phi1(phi1), .phi2(phi2),
    .cs_ram(cs_ram), .cs_ppu(cs_ppu), .cs_io(cs_io), .cs_cram(cs_cram),
    .cs_rom(cs_rom), .bus_addr(bus_addr), .ram_offs(ram_offs),
    .ppu_sel(ppu_sel), .io_sel(io_sel), .bus_wdata(bus_wdata),
    .drive_en(drive_en), .rd_data(rd_data), .cyc_done(cyc_done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_sel(input logic [15:0] a);
    exp_sel = 5'b0;
    if (a[15])                  exp_sel[4] = 1'b1;
    else if (a[15:13] == 3'b000) exp_sel[0] = 1'b1;
    else if (a[15:13] == 3'b001) exp_sel[1] = 1'b1;
    else if (a[15:5] == 11'h200) exp_sel[2] = 1'b1;
    else if (a[15:13] == 3'b011) exp_sel[3] = 1'b1;
  endfunction

  initial begin
    logic [7:0] last;
    logic [4:0] sel, act_sel;
    rst = 1'b1; cpu_addr = 16'h0; cpu_rw = 1'b1; cpu_wdata = 8'h0;
    last = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    // R10: quiet while in reset
    chk(!phi1 && !phi2, "R10 phases in reset", {phi1, phi2}, 0);
    chk({cs_ram, cs_ppu, cs_io, cs_cram, cs_rom} == 0, "R10 selects in reset",
        {cs_ram, cs_ppu, cs_io, cs_cram, cs_rom}, 0);
    chk(!drive_en && !cyc_done, "R10 drive/done in reset", {drive_en, cyc_done}, 0);
    chk(rd_data == 8'h00, "R10 rd_data in reset", rd_data, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4096 + 8; i++) begin
      logic [15:0] a;
      logic rw;
      logic [7:0] wd;
      if (i < 4096) a = 16'(i * 16 + (i % 16));
      else a = 16'(16'h4018 + (i - 4096) * 3);
      rw = (i % 3) != 0;
      wd = 8'(i) ^ 8'hC3;
      for (int s = 0; s < CYC; s++) begin
        if (s == 0) begin cpu_addr = a; cpu_rw = rw; cpu_wdata = wd; end
        #1;
        chk(phi1 == (s < PL), "R1 phase one", phi1, s < PL);
        chk(phi2 == (s >= HALF && s < HALF + PL), "R1 phase two", phi2, s >= HALF && s < HALF + PL);
        if (s == PL) chk(!phi2, "R2 dead after phase one", phi2, 0);
        if (s == CYC - 1) chk(!phi1, "R2 dead after phase two", phi1, 0);
        act_sel = {cs_rom, cs_cram, cs_io, cs_ppu, cs_ram};
        sel = (s >= HALF && s < HALF + PL) ? exp_sel(a) : 5'b0;
        chk(act_sel == sel, "R4 chip selects", act_sel, sel);
        if (s >= HALF && s < HALF + PL) begin
          chk(bus_addr == a, "R3 sampled address", bus_addr, a);
          chk(ram_offs == a[10:0] && ppu_sel == a[2:0] && io_sel == a[4:0],
              "R5 mirrored offsets", {ram_offs, ppu_sel, io_sel}, {a[10:0], a[2:0], a[4:0]});
        end
        chk(drive_en == (!rw && s >= HALF + WD && s < HALF + PL), "R6 drive enable",
            drive_en, !rw && s >= HALF + WD && s < HALF + PL);
        if (drive_en) chk(bus_wdata == wd, "R6 write data", bus_wdata, wd);
        chk(cyc_done == (s == CYC - 1), "R9 done strobe", cyc_done, s == CYC - 1);
        if (s == CYC - 1) begin
          if (!rw) last = wd;
          else if (exp_sel(a) != 0) last = a[7:0] ^ a[15:8] ^ 8'h5A;
          if (rw && exp_sel(a) == 0)
            chk(rd_data == last, "R8 open bus value", rd_data, last);
          else
            chk(rd_data == last, "R7 captured data", rd_data, last);
        end else begin
          chk(rd_data == last, "R7 data held", rd_data, last);
        end
        @(negedge clk);
      end
    end
    // R10: reset in the middle of a write cycle
    cpu_addr = 16'h0123; cpu_rw = 1'b0; cpu_wdata = 8'hA5;
    repeat (HALF + WD) @(negedge clk);
    #1;
    chk(drive_en, "R6 drive before reset", drive_en, 1);
    rst = 1'b1;
    #1;
    chk(!drive_en && !phi2 && !cs_ram, "R10 reset drops drive", {drive_en, phi2, cs_ram}, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(phi1 && !phi2, "R10 restart in phase one", {phi1, phi2}, 2'b10);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule